// File: doc/BRIEF.md
# 64b/66b Receive Block Decoder

This block sits on the receive side of a 10 Gb/s serial Ethernet PHY, after block alignment. Each cycle with `in_valid` set, it accepts one 66-bit block: a 2-bit sync header and a 64-bit payload. The payload can first be bit-reversed, and is then descrambled by a self-synchronous descrambler. The block decodes the result into eight byte lanes of media-independent-interface data, with one control flag per lane.

Decoding depends on the sync header and, for control blocks, on the block type byte in payload byte 0. Data blocks pass straight through. The block handles every control block type: all-control blocks, starts, terminates and ordered sets. Anything malformed (a bad header, an unknown block type, an unmapped 7-bit control code, an unknown ordered-set code) becomes the Error character 0xFE in the lanes it affects. The output is registered, so it appears one clock after the input. Lane k is `out_data[8k+7:8k]` and its control flag is `out_ctrl[k]`.

Top module: `baser_rx_decoder`

## Requirements
- R1: Output timing and reset.
  - `out_data` and `out_ctrl` are registered one clock after an accepted input.
  - `out_valid` equals `in_valid` delayed by one clock.
  - Reset clears `out_valid`, `out_data` and `out_ctrl` to zero.
- R2: While `in_valid` is low, `out_data` and `out_ctrl` hold their values and the descrambler state does not advance.
- R3: Descrambler (when DESCRAMBLE_EN=1).
  - It uses the polynomial x^58 + x^39 + 1 and processes payload bits LSB first.
  - Each output bit equals the input bit XOR state[38] XOR state[57].
  - The received bit is then shifted into the 58-bit state, which is zero after reset.
- R4: With REVERSE_EN=1, payload bit i is swapped with bit 63-i and the two header bits are swapped. This happens before descrambling and before the header is examined.
- R5: Sync header 2'b01 is a data block. All 8 payload bytes appear unchanged on their lanes and `out_ctrl` is 8'h00.
- R6: Sync header 2'b00 or 2'b11 gives 0xFE in every lane with `out_ctrl` = 8'hFF.
- R7: Control blocks and control codes.
  - Header 2'b10 marks a control block.
  - Lane i's 7-bit code is payload bits [8+7i +: 7].
  - Codes map as 0x00→0x07, 0x06→0x06, 0x1E→0xFE, 0x2D→0x1C, 0x33→0x3C, 0x4B→0x7C, 0x55→0xBC, 0x66→0xDC and 0x78→0xF7. Any other code maps to 0xFE.
  - Type 0x1E puts the mapped codes in all lanes with `out_ctrl` = 8'hFF.
- R8: Start blocks.
  - Type 0x78 gives Start (0xFB) in lane 0 and payload bytes 1..7 as data in lanes 1..7, with `out_ctrl` = 8'h01.
  - Type 0x33 gives mapped codes in lanes 0..3, Start in lane 4 and bytes 5..7 as data, with `out_ctrl` = 8'h1F.
- R9: Terminate blocks.
  - Types 0x87, 0x99, 0xAA, 0xB4, 0xCC, 0xD2, 0xE1 and 0xFF terminate in lane n = 0..7 respectively.
  - Lanes below n carry payload bytes 1..n as data and lane n carries Terminate (0xFD).
  - Lanes above n carry their mapped codes.
  - `out_ctrl` = 8'hFF << n.
- R10: Ordered-set blocks.
  - The code in the low nibble of byte 4 sets lane 0; the code in the high nibble sets lane 4.
  - Code 0x0 maps to 0x9C and 0xF maps to 0x5C; any other code maps to 0xFE.
  - Type 0x4B: ordered set in lane 0, bytes 1..3 as data, mapped codes in lanes 4..7, `out_ctrl` = 8'hF1.
  - Type 0x2D: mapped codes in lanes 0..3, ordered set in lane 4, bytes 5..7 as data, `out_ctrl` = 8'h1F.
  - Type 0x55: ordered sets in lanes 0 and 4, `out_ctrl` = 8'h11.
  - Type 0x66: ordered set in lane 0 and Start in lane 4, `out_ctrl` = 8'h11.
- R11: A control block with any other type byte gives 0xFE in every lane with `out_ctrl` = 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input block present this cycle |
| in_hdr | input | 2 | Sync header of the block |
| in_data | input | 64 | Scrambled block payload |
| out_valid | output | 1 | Decoded word present |
| out_data | output | 64 | Eight decoded lane bytes |
| out_ctrl | output | 8 | Per-lane control flags |

## Verification
Each terminate lane gets its own block, so a wrong type-to-lane table or a wrong mask boundary would put Terminate or a control flag in a neighbouring lane. Ordered-set blocks carry different codes in the two nibbles. A design that read the wrong nibble, or that mapped Signal as Sequence, would show the wrong character in lane 0 or lane 4. Idle gaps between scrambled words expose a descrambler that advances on invalid cycles, because every later word would then come out garbled. A second instance with reversal enabled and descrambling disabled shows whether the header is examined after the bits are swapped.

// File: rtl/baser_rx_pkg.sv
package baser_rx_pkg;
   localparam logic [7:0] XG_IDLE  = 8'h07;
   localparam logic [7:0] XG_LPI   = 8'h06;
   localparam logic [7:0] XG_START = 8'hFB;
   localparam logic [7:0] XG_TERM  = 8'hFD;
   localparam logic [7:0] XG_ERROR = 8'hFE;
   localparam logic [7:0] XG_SEQ   = 8'h9C;
   localparam logic [7:0] XG_SIG   = 8'h5C;

   localparam logic [1:0] HDR_DATA = 2'b01;
   localparam logic [1:0] HDR_CTRL = 2'b10;

   typedef enum logic [7:0] {
      BT_ALL_CTRL = 8'h1E,
      BT_OS_HI    = 8'h2D,
      BT_START_HI = 8'h33,
      BT_OS_START = 8'h66,
      BT_OS_BOTH  = 8'h55,
      BT_START_LO = 8'h78,
      BT_OS_LO    = 8'h4B,
      BT_TERM0    = 8'h87,
      BT_TERM1    = 8'h99,
      BT_TERM2    = 8'hAA,
      BT_TERM3    = 8'hB4,
      BT_TERM4    = 8'hCC,
      BT_TERM5    = 8'hD2,
      BT_TERM6    = 8'hE1,
      BT_TERM7    = 8'hFF
   } blk_type_e;

   function automatic logic [7:0] map_ctrl_code(input logic [6:0] code);
      logic [7:0] r;
      case (code)
         7'h00:   r = XG_IDLE;
         7'h06:   r = XG_LPI;
         7'h1E:   r = XG_ERROR;
         7'h2D:   r = 8'h1C;
         7'h33:   r = 8'h3C;
         7'h4B:   r = 8'h7C;
         7'h55:   r = 8'hBC;
         7'h66:   r = 8'hDC;
         7'h78:   r = 8'hF7;
         default: r = XG_ERROR;
      endcase
      return r;
   endfunction

   function automatic logic [7:0] map_os_code(input logic [3:0] code);
      logic [7:0] r;
      case (code)
         4'h0:    r = XG_SEQ;
         4'hF:    r = XG_SIG;
         default: r = XG_ERROR;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/brd_bitrev.sv
module brd_bitrev #(
   parameter int DATA_W     = 64,
   parameter int HDR_W      = 2,
   parameter bit REVERSE_EN = 1'b0
) (
   input  logic [DATA_W-1:0] din,
   input  logic [HDR_W-1:0]  hin,
   output logic [DATA_W-1:0] dout,
   output logic [HDR_W-1:0]  hout
);
   generate
      if (REVERSE_EN) begin : g_rev
         for (genvar i = 0; i < DATA_W; i++) begin : g_d
            assign dout[i] = din[DATA_W-1-i];
         end
         for (genvar j = 0; j < HDR_W; j++) begin : g_h
            assign hout[j] = hin[HDR_W-1-j];
         end
      end else begin : g_pass
         assign dout = din;
         assign hout = hin;
      end
   endgenerate
endmodule

// File: rtl/brd_descrambler.sv
module brd_descrambler #(
   parameter int DATA_W        = 64,
   parameter int POLY_LEN      = 58,
   parameter int POLY_TAP      = 39,
   parameter bit DESCRAMBLE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam int EXT_W = DATA_W + POLY_LEN;
   localparam int OFS_T = POLY_LEN - POLY_TAP;

   generate
      if (DESCRAMBLE_EN) begin : g_on
         logic [POLY_LEN-1:0] hist;
         logic [EXT_W-1:0]    ext;
         assign ext = {din, hist};
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign dout[i] = ext[POLY_LEN+i] ^ ext[OFS_T+i] ^ ext[i];
         end
         always_ff @(posedge clk) begin
            if (!rst_n)   hist <= '0;
            else if (adv) hist <= ext[EXT_W-1 -: POLY_LEN];
         end
      end else begin : g_off
         logic unused_ok;
         assign unused_ok = &{clk, rst_n, adv};
         assign dout = din;
      end
   endgenerate
endmodule

// File: rtl/brd_block_decode.sv
module brd_block_decode
   import baser_rx_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int HDR_W  = 2
) (
   input  logic [HDR_W-1:0]    hdr,
   input  logic [DATA_W-1:0]   pay,
   output logic [DATA_W-1:0]   dec_data,
   output logic [DATA_W/8-1:0] dec_ctrl
);
   localparam int LANES  = DATA_W / 8;
   localparam int CODE_W = 7;

   logic [7:0]        cc    [LANES];
   logic [7:0]        bytes [LANES];
   logic [DATA_W-1:0] shift1;
   logic [7:0]        os_lo, os_hi;

   assign shift1 = pay >> 8;
   assign os_lo  = map_os_code(pay[35:32]);
   assign os_hi  = map_os_code(pay[39:36]);

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assign cc[l]    = map_ctrl_code(pay[8 + CODE_W*l +: CODE_W]);
         assign bytes[l] = pay[8*l +: 8];
      end
   endgenerate

   logic       is_term;
   logic [2:0] term_lane;
   always_comb begin
      is_term   = 1'b1;
      term_lane = 3'd0;
      case (pay[7:0])
         BT_TERM0: term_lane = 3'd0;
         BT_TERM1: term_lane = 3'd1;
         BT_TERM2: term_lane = 3'd2;
         BT_TERM3: term_lane = 3'd3;
         BT_TERM4: term_lane = 3'd4;
         BT_TERM5: term_lane = 3'd5;
         BT_TERM6: term_lane = 3'd6;
         BT_TERM7: term_lane = 3'd7;
         default:  is_term   = 1'b0;
      endcase
   end

   always_comb begin
      for (int l = 0; l < LANES; l++) dec_data[8*l +: 8] = XG_ERROR;
      dec_ctrl = '1;
      if (hdr == HDR_DATA) begin
         dec_data = pay;
         dec_ctrl = '0;
      end else if (hdr == HDR_CTRL) begin
         if (is_term) begin
            for (int l = 0; l < LANES; l++) begin
               if (l < int'(term_lane)) begin
                  dec_data[8*l +: 8] = shift1[8*l +: 8];
                  dec_ctrl[l]        = 1'b0;
               end else if (l == int'(term_lane)) begin
                  dec_data[8*l +: 8] = XG_TERM;
               end else begin
                  dec_data[8*l +: 8] = cc[l];
               end
            end
         end else begin
            case (pay[7:0])
               BT_ALL_CTRL: begin
                  for (int l = 0; l < LANES; l++) dec_data[8*l +: 8] = cc[l];
               end
               BT_START_LO: begin
                  dec_data = {shift1[55:0], XG_START};
                  dec_ctrl = 8'h01;
               end
               BT_START_HI: begin
                  dec_data = {bytes[7], bytes[6], bytes[5], XG_START,
                              cc[3], cc[2], cc[1], cc[0]};
                  dec_ctrl = 8'h1F;
               end
               BT_OS_HI: begin
                  dec_data = {bytes[7], bytes[6], bytes[5], os_hi,
                              cc[3], cc[2], cc[1], cc[0]};
                  dec_ctrl = 8'h1F;
               end
               BT_OS_LO: begin
                  dec_data = {cc[7], cc[6], cc[5], cc[4],
                              bytes[3], bytes[2], bytes[1], os_lo};
                  dec_ctrl = 8'hF1;
               end
               BT_OS_BOTH: begin
                  dec_data = {bytes[7], bytes[6], bytes[5], os_hi,
                              bytes[3], bytes[2], bytes[1], os_lo};
                  dec_ctrl = 8'h11;
               end
               BT_OS_START: begin
                  dec_data = {bytes[7], bytes[6], bytes[5], XG_START,
                              bytes[3], bytes[2], bytes[1], os_lo};
                  dec_ctrl = 8'h11;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/baser_rx_decoder.sv
module baser_rx_decoder
   import baser_rx_pkg::*;
#(
   parameter int DATA_W        = 64,
   parameter int HDR_W         = 2,
   parameter bit REVERSE_EN    = 1'b0,
   parameter bit DESCRAMBLE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        in_hdr,
   input  logic [63:0]       in_data,
   output logic              out_valid,
   output logic [63:0]       out_data,
   output logic [7:0]        out_ctrl
);
   localparam int LANES = DATA_W / 8;

   generate
      if (DATA_W != 64) begin : g_bad_w
         $error("baser_rx_decoder: DATA_W must be 64");
      end
      if (HDR_W != 2) begin : g_bad_h
         $error("baser_rx_decoder: HDR_W must be 2");
      end
   endgenerate

   logic [DATA_W-1:0] rev_data, desc_data, dec_data;
   logic [HDR_W-1:0]  rev_hdr;
   logic [LANES-1:0]  dec_ctrl;

   brd_bitrev #(.DATA_W(DATA_W), .HDR_W(HDR_W), .REVERSE_EN(REVERSE_EN)) u_rev (
      .din(in_data), .hin(in_hdr), .dout(rev_data), .hout(rev_hdr));

   brd_descrambler #(.DATA_W(DATA_W), .DESCRAMBLE_EN(DESCRAMBLE_EN)) u_desc (
      .clk(clk), .rst_n(rst_n), .adv(in_valid), .din(rev_data), .dout(desc_data));

   brd_block_decode #(.DATA_W(DATA_W), .HDR_W(HDR_W)) u_dec (
      .hdr(rev_hdr), .pay(desc_data), .dec_data(dec_data), .dec_ctrl(dec_ctrl));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_ctrl  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data <= dec_data;
            out_ctrl <= dec_ctrl;
         end
      end
   end
endmodule

// File: rtl/baser_rx_decoder_chk.sv
module baser_rx_decoder_chk #(
   parameter bit REVERSE_EN = 1'b0
) (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [1:0]  in_hdr,
   input logic        out_valid,
   input logic [63:0] out_data,
   input logic [7:0]  out_ctrl
);
   localparam logic [1:0] DATA_HDR = REVERSE_EN ? 2'b10 : 2'b01;

   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (out_valid == $past(in_valid)));

   a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_data) && $stable(out_ctrl)));

   a_r5_data_ctrl_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_hdr == DATA_HDR) |=> (out_ctrl == 8'h00));

   a_r6_bad_header: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_hdr == 2'b00 || in_hdr == 2'b11)) |=>
      (out_ctrl == 8'hFF && out_data == {8{8'hFE}}));
endmodule

bind baser_rx_decoder baser_rx_decoder_chk #(.REVERSE_EN(REVERSE_EN)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hdr(in_hdr),
   .out_valid(out_valid), .out_data(out_data), .out_ctrl(out_ctrl));

// File: tb/baser_rx_decoder_test.sv
module baser_rx_decoder_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        in_valid = 1'b0, r_valid = 1'b0;
   logic [1:0]  in_hdr = 2'b00, r_hdr = 2'b00;
   logic [63:0] in_data = '0, r_data = '0;
   logic        out_valid, r_out_valid;
   logic [63:0] out_data, r_out_data;
   logic [7:0]  out_ctrl, r_out_ctrl;

   baser_rx_decoder uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hdr(in_hdr), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data), .out_ctrl(out_ctrl));

   baser_rx_decoder #(.REVERSE_EN(1'b1), .DESCRAMBLE_EN(1'b0)) uut_rev (
      .clk(clk), .rst_n(rst_n), .in_valid(r_valid), .in_hdr(r_hdr), .in_data(r_data),
      .out_valid(r_out_valid), .out_data(r_out_data), .out_ctrl(r_out_ctrl));

   int checks = 0, errors = 0;
   logic [57:0] sc = '0;

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [63:0] rev64(input logic [63:0] v);
      logic [63:0] r;
      for (int i = 0; i < 64; i++) r[i] = v[63-i];
      return r;
   endfunction

   // scramble then present one block; output sampled one clock later
   task automatic send(input logic [1:0] h, input logic [63:0] plain);
      logic [63:0] s;
      logic b;
      for (int i = 0; i < 64; i++) begin
         b = plain[i] ^ sc[38] ^ sc[57];
         s[i] = b;
         sc = {sc[56:0], b};
      end
      @(negedge clk);
      in_valid = 1'b1; in_hdr = h; in_data = s;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic expect_out(input string req, input logic [63:0] d, input logic [7:0] c);
      chk(req, {63'd0, out_valid}, 64'd1);
      chk(req, out_data, d);
      chk(req, {56'd0, out_ctrl}, {56'd0, c});
   endtask

   task automatic t_reset;
      chk("R1", {63'd0, out_valid}, 64'd0);
      chk("R1", out_data, 64'd0);
      chk("R1", {56'd0, out_ctrl}, 64'd0);
   endtask

   task automatic t_data;
      send(2'b01, 64'h0123456789ABCDEF); expect_out("R5", 64'h0123456789ABCDEF, 8'h00);
      send(2'b01, 64'hFFFF0000A5A5C3C3); expect_out("R3", 64'hFFFF0000A5A5C3C3, 8'h00);
   endtask

   task automatic t_ctrl;
      send(2'b10, {56'd0, 8'h1E}); expect_out("R7", {8{8'h07}}, 8'hFF);
      send(2'b10, {7'h78, 7'h66, 7'h00, 7'h2D, 7'h00, 7'h11, 7'h06, 7'h1E, 8'h1E});
      expect_out("R7", 64'hF7DC071C07FE06FE, 8'hFF);
   endtask

   task automatic t_start;
      send(2'b10, 64'hD555555555555578); expect_out("R8", 64'hD5555555555555FB, 8'h01);
      send(2'b10, {8'hC3, 8'hB2, 8'hA1, 4'h0, 7'h00, 7'h00, 7'h00, 7'h00, 8'h33});
      expect_out("R8", 64'hC3B2A1FB07070707, 8'h1F);
   endtask

   task automatic t_term;
      logic [7:0] types [8] = '{8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF};
      for (int n = 0; n < 8; n++) begin
         logic [63:0] p, e;
         p = '0; p[7:0] = types[n];
         for (int k = 1; k <= n; k++) p[8*k +: 8] = 8'(8'h10 + k);
         for (int l = 0; l < 8; l++)
            e[8*l +: 8] = (l < n) ? 8'(8'h11 + l) : (l == n) ? 8'hFD : 8'h07;
         send(2'b10, p);
         expect_out("R9", e, 8'(8'hFF << n));
      end
   endtask

   task automatic t_os;
      send(2'b10, {7'h00, 7'h00, 7'h00, 7'h00, 4'h0, 8'h13, 8'h12, 8'h11, 8'h4B});
      expect_out("R10", 64'h070707071312119C, 8'hF1);
      send(2'b10, {8'h33, 8'h22, 8'h11, 4'hF, 7'h00, 7'h00, 7'h00, 7'h00, 8'h2D});
      expect_out("R10", 64'h3322115C07070707, 8'h1F);
      send(2'b10, {8'h57, 8'h56, 8'h55, 4'hF, 4'h0, 8'h53, 8'h52, 8'h51, 8'h55});
      expect_out("R10", 64'h5756555C5352519C, 8'h11);
      send(2'b10, {8'hE7, 8'hE6, 8'hE5, 4'h0, 4'h3, 8'hE3, 8'hE2, 8'hE1, 8'h66});
      expect_out("R10", 64'hE7E6E5FBE3E2E1FE, 8'h11);
   endtask

   task automatic t_errors;
      send(2'b10, 64'h1122334455667700); expect_out("R11", {8{8'hFE}}, 8'hFF);
      send(2'b00, 64'h0123456789ABCDEF); expect_out("R6", {8{8'hFE}}, 8'hFF);
      send(2'b11, 64'h0123456789ABCDEF); expect_out("R6", {8{8'hFE}}, 8'hFF);
   endtask

   task automatic t_hold;
      send(2'b01, 64'hCAFEF00D12345678);
      expect_out("R2", 64'hCAFEF00D12345678, 8'h00);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         in_hdr = 2'b10; in_data = 64'hDEADBEEF00000000 | 64'(i);
         @(negedge clk);
         chk("R2", {63'd0, out_valid}, 64'd0);
         chk("R2", out_data, 64'hCAFEF00D12345678);
         chk("R2", {56'd0, out_ctrl}, 64'd0);
      end
      send(2'b01, 64'h0F1E2D3C4B5A6978); expect_out("R2", 64'h0F1E2D3C4B5A6978, 8'h00);
   endtask

   task automatic t_reverse;
      @(negedge clk);
      r_valid = 1'b1; r_hdr = 2'b10; r_data = rev64(64'h0123456789ABCDEF);
      @(negedge clk);
      r_valid = 1'b0;
      chk("R4", r_out_data, 64'h0123456789ABCDEF);
      chk("R4", {56'd0, r_out_ctrl}, 64'd0);
      @(negedge clk);
      r_valid = 1'b1; r_hdr = 2'b01; r_data = rev64({56'd0, 8'h1E});
      @(negedge clk);
      r_valid = 1'b0;
      chk("R4", r_out_data, {8{8'h07}});
      chk("R4", {56'd0, r_out_ctrl}, 64'hFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      t_data;
      t_ctrl;
      t_start;
      t_term;
      t_os;
      t_errors;
      t_hold;
      t_reverse;
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 200000);
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule